// File: doc/BRIEF.md
# Strobe Window Calibration Controller

This block runs the search for a safe sampling tap for a reference strobe without software taking part. A separate detector (not part of this block) sweeps a set of sampling taps against the device clock. It gathers a 16-bit hazard map in which a 1 marks a tap near a setup or hold violation. The controller turns the detector on with fine step size and counts a programmable number of strobe edges while the map builds up. It then scans the map and picks the middle of the widest clean stretch of taps.

The end taps of the map always read as hazards. If no hazard shows up between them, the fine steps were too small to reach a transition. In that case the controller re-arms the detector once with coarse step size and measures again. If the coarse pass also gives no usable map, the controller reports a failure. The result is the chosen tap, the step size it was found with, and a done level that stays up until the next start.

Top module: `strobe_window_cal`

## Requirements
- R1: After reset, `det_enable` and `done` and `fail` are 0, `tap_sel` is 0 and `zoom_fine` is 1.
- R2: A `start` pulse seen while idle or done makes `det_enable`=1 and `zoom_fine`=1 and clears `done` and `fail` on the next clock.
- R3: Once armed, the block counts cycles with `edge_pulse`=1 and begins evaluation only after `edge_limit` of them. A pulse in the same cycle as the accepted `start` is not counted. With `edge_limit`=0 evaluation begins without any pulse.
- R4: The chosen tap is the center, rounded down, of the longest run of consecutive 0 bits in `hazard_map` (bit 0 is tap 0): run low index + (run length − 1)/2.
- R5: When two runs have the same length, the run with the lower indices wins.
- R6: A map is usable when at least one of bits 1..14 is 1 and at least one bit is 0. An unusable map on the fine pass sets `zoom_fine`=0, drops `det_enable` for exactly one cycle and restarts the edge count.
- R7: An unusable map on the coarse pass ends the run with `done`=1, `fail`=1 and `tap_sel`=0.
- R8: While `done`=1, `det_enable` is 0, and `tap_sel`, `zoom_fine` and `done` hold until the next `start`, whatever the map and pulses do.
- R9: A `start` pulse while a measurement is in progress is ignored and does not restart the edge count.
- R10: On success `zoom_fine` reports the step size used: 1 after the fine pass, 0 after the coarse retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (single-cycle pulse) |
| edge_pulse | input | 1 | One cycle high per strobe edge seen by the detector |
| edge_limit | input | 16 | Number of strobe edges to accumulate per pass |
| hazard_map | input | 16 | Accumulated hazard map from the detector, bit i = tap i |
| det_enable | output | 1 | Detector processing enable; its rising edge restarts accumulation |
| zoom_fine | output | 1 | Step size: 1 fine, 0 coarse |
| tap_sel | output | 4 | Chosen sampling tap |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | No usable map on either pass |

## Verification
Two events can land in the same cycle: accepting a new `start` from the done state and a strobe `edge_pulse`. The bench drives both in one cycle with an edge limit of 2. It judges from the ports that `done` stays low after one further pulse and rises only after the second, so the coincident pulse was not counted. A second overlap is a `start` arriving mid-accumulation together with the count. The result must appear after the original limit, not a restarted one.

// File: rtl/swcal_pkg.sv
package swcal_pkg;
  parameter int unsigned MAP_W = 16;
  localparam int unsigned SEL_W = $clog2(MAP_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_EVAL,
    ST_REARM,
    ST_DONE
  } cal_state_e;

  typedef struct packed {
    logic             usable;
    logic             transition;
    logic             any_zero;
    logic [SEL_W-1:0] tap;
  } scan_res_t;

  // Longest run of zeros, center rounded down, lowest run wins ties.
  function automatic scan_res_t scan_map(input logic [MAP_W-1:0] m);
    scan_res_t r;
    int run_lo;
    int run_len;
    int best_lo;
    int best_len;
    run_lo   = 0;
    run_len  = 0;
    best_lo  = 0;
    best_len = 0;
    r.any_zero = 1'b0;
    for (int i = 0; i < int'(MAP_W); i++) begin
      if (!m[i]) begin
        if (run_len == 0) run_lo = i;
        run_len++;
        r.any_zero = 1'b1;
        if (run_len > best_len) begin
          best_len = run_len;
          best_lo  = run_lo;
        end
      end else begin
        run_len = 0;
      end
    end
    r.transition = |m[MAP_W-2:1];
    r.usable     = r.transition & r.any_zero;
    if (r.usable && best_len > 0)
      r.tap = SEL_W'(best_lo + (best_len - 1) / 2);
    else
      r.tap = '0;
    return r;
  endfunction
endpackage

// File: rtl/cal_edge_counter.sv
module cal_edge_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic             pulse,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  logic [CNT_W-1:0] cnt_q;

  assign reached = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (clear)                       cnt_q <= '0;
    else if (count_en && pulse && !reached) cnt_q <= cnt_q + 1'b1;
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && pulse && !reached && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/cal_map_scan.sv
module cal_map_scan
  import swcal_pkg::*;
(
  input  logic [MAP_W-1:0] map,
  output logic             usable,
  output logic             transition,
  output logic [SEL_W-1:0] tap
);
  scan_res_t res;

  always_comb begin
    res        = scan_map(map);
    usable     = res.usable;
    transition = res.transition;
    tap        = res.tap;
  end
endmodule

// File: rtl/strobe_window_cal.sv
module strobe_window_cal
  import swcal_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             edge_pulse,
  input  logic [CNT_W-1:0] edge_limit,
  input  logic [MAP_W-1:0] hazard_map,
  output logic             det_enable,
  output logic             zoom_fine,
  output logic [SEL_W-1:0] tap_sel,
  output logic             done,
  output logic             fail
);
  cal_state_e       state_q;
  logic             reached;
  logic             scan_usable;
  logic             scan_transition;
  logic [SEL_W-1:0] scan_tap;

  // Named events for the checks below.
  logic accept_start;
  logic eval_fire;
  logic retry_fire;
  logic fail_fire;
  logic ok_fire;
  logic cnt_clear;

  assign accept_start = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign eval_fire    = (state_q == ST_EVAL);
  assign ok_fire      = eval_fire && scan_usable;
  assign retry_fire   = eval_fire && !scan_usable && zoom_fine;
  assign fail_fire    = eval_fire && !scan_usable && !zoom_fine;
  assign cnt_clear    = accept_start || (state_q == ST_REARM);

  cal_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .count_en (state_q == ST_ACCUM),
    .pulse    (edge_pulse),
    .limit    (edge_limit),
    .reached  (reached)
  );

  cal_map_scan u_scan (
    .map        (hazard_map),
    .usable     (scan_usable),
    .transition (scan_transition),
    .tap        (scan_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      det_enable <= 1'b0;
      zoom_fine  <= 1'b1;
      tap_sel    <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept_start) begin
            state_q    <= ST_ACCUM;
            det_enable <= 1'b1;
            zoom_fine  <= 1'b1;
            done       <= 1'b0;
            fail       <= 1'b0;
          end
        end
        ST_ACCUM: begin
          if (reached) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          det_enable <= 1'b0;
          if (ok_fire) begin
            state_q <= ST_DONE;
            tap_sel <= scan_tap;
            done    <= 1'b1;
          end else if (retry_fire) begin
            state_q   <= ST_REARM;
            zoom_fine <= 1'b0;
          end else begin
            state_q <= ST_DONE;
            tap_sel <= '0;
            done    <= 1'b1;
            fail    <= 1'b1;
          end
        end
        ST_REARM: begin
          state_q    <= ST_ACCUM;
          det_enable <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (det_enable && zoom_fine && !done && !fail));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !det_enable);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(tap_sel) && $stable(zoom_fine)));

  assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && tap_sel == '0));

  assert_retry_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fire |=> (!det_enable && !zoom_fine));

  assert_retry_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_fire |=> ##1 det_enable);

  assert_tap_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ok_fire |-> (scan_transition && !hazard_map[scan_tap]));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_ACCUM && !reached) |=> (state_q == ST_ACCUM));

  assert_coarse_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_fire |=> (fail && !zoom_fine));
endmodule

// File: tb/sim_strobe_window_cal.sv
module sim_strobe_window_cal;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        edge_pulse = 1'b0;
  logic [15:0] edge_limit = 16'd0;
  logic [15:0] hazard_map = 16'hFFFF;
  logic        det_enable;
  logic        zoom_fine;
  logic [3:0]  tap_sel;
  logic        done;
  logic        fail;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strobe_window_cal u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_pulse(edge_pulse),
    .edge_limit(edge_limit), .hazard_map(hazard_map),
    .det_enable(det_enable), .zoom_fine(zoom_fine), .tap_sel(tap_sel),
    .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Brute-force reference: try every window, keep the first strictly longer one.
  function automatic int ref_tap(input logic [15:0] m);
    int best_len = 0;
    int best_lo = 0;
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = lo; hi < 16; hi++) begin
        bit clean = 1'b1;
        for (int k = lo; k <= hi; k++) if (m[k]) clean = 1'b0;
        if (clean && (hi - lo + 1) > best_len) begin
          best_len = hi - lo + 1;
          best_lo  = lo;
        end
      end
    end
    return best_lo + (best_len - 1) / 2;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) edge_pulse = 1'b1;
      @(negedge clk) edge_pulse = 1'b0;
    end
  endtask

  task automatic kick;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset;
    chk(det_enable == 0, "R1", "det_enable", int'(det_enable), 0);
    chk(done == 0 && fail == 0, "R1", "done|fail", int'({done, fail}), 0);
    chk(tap_sel == 0, "R1", "tap_sel", int'(tap_sel), 0);
    chk(zoom_fine == 1, "R1", "zoom_fine", int'(zoom_fine), 1);
  endtask

  task automatic t_fine_map(input logic [15:0] m, input int lim, input string req);
    hazard_map = m;
    edge_limit = 16'(lim);
    kick();
    chk(det_enable && zoom_fine && !done && !fail, "R2", "armed",
        int'({det_enable, zoom_fine, done, fail}), 4'b1100);
    give_pulses(lim - 1);
    idle(3);
    chk(done == 0, "R3", "early done", int'(done), 0);
    give_pulses(1);
    idle(4);
    chk(done == 1 && fail == 0, req, "done/fail", int'({done, fail}), 2);
    chk(int'(tap_sel) == ref_tap(m), req, "tap_sel", int'(tap_sel), ref_tap(m));
    chk(det_enable == 0, "R8", "det_enable at done", int'(det_enable), 0);
    chk(zoom_fine == 1, "R10", "fine zoom", int'(zoom_fine), 1);
  endtask

  task automatic t_limit_zero;
    hazard_map = 16'hE019;
    edge_limit = 16'd0;
    kick();
    idle(4);
    chk(done == 1, "R3", "limit zero done", int'(done), 1);
    chk(tap_sel == 4'd8, "R3", "limit zero tap", int'(tap_sel), 8);
  endtask

  task automatic t_retry;
    int lows;
    hazard_map = 16'h8001;
    edge_limit = 16'd2;
    kick();
    give_pulses(2);
    lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!det_enable) lows++;
    end
    chk(lows == 1, "R6", "enable drop cycles", lows, 1);
    chk(zoom_fine == 0 && done == 0, "R6", "coarse armed",
        int'({zoom_fine, done}), 0);
    hazard_map = 16'hE019;
    give_pulses(1);
    idle(3);
    chk(done == 0, "R6", "recount early done", int'(done), 0);
    give_pulses(1);
    idle(4);
    chk(done == 1 && fail == 0, "R10", "coarse ok", int'({done, fail}), 2);
    chk(tap_sel == 4'd8, "R10", "coarse tap", int'(tap_sel), 8);
    chk(zoom_fine == 0, "R10", "zoom coarse", int'(zoom_fine), 0);
  endtask

  task automatic t_fail(input logic [15:0] m);
    hazard_map = m;
    edge_limit = 16'd1;
    kick();
    give_pulses(1);
    idle(5);
    chk(done == 0 && zoom_fine == 0, "R7", "retry pending",
        int'({done, zoom_fine}), 0);
    give_pulses(1);
    idle(4);
    chk(done == 1 && fail == 1, "R7", "fail flag", int'({done, fail}), 3);
    chk(tap_sel == 0, "R7", "fail tap", int'(tap_sel), 0);
  endtask

  task automatic t_hold;
    logic [3:0] keep;
    t_fine_map(16'hE001, 1, "R4");
    keep = tap_sel;
    hazard_map = 16'h9831;
    give_pulses(3);
    idle(2);
    chk(done == 1 && tap_sel == keep && det_enable == 0, "R8", "hold",
        int'(tap_sel), int'(keep));
  endtask

  task automatic t_busy_start;
    hazard_map = 16'h8301;
    edge_limit = 16'd3;
    kick();
    give_pulses(2);
    kick();
    give_pulses(1);
    idle(4);
    chk(done == 1, "R9", "busy start ignored", int'(done), 1);
    chk(tap_sel == 4'd4, "R9", "busy tap", int'(tap_sel), 4);
  endtask

  task automatic t_start_with_pulse;
    hazard_map = 16'hE019;
    edge_limit = 16'd2;
    @(negedge clk) begin start = 1'b1; edge_pulse = 1'b1; end
    @(negedge clk) begin start = 1'b0; edge_pulse = 1'b0; end
    give_pulses(1);
    idle(3);
    chk(done == 0, "R3", "coincident pulse uncounted", int'(done), 0);
    give_pulses(1);
    idle(4);
    chk(done == 1, "R3", "done after limit", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fine_map(16'hE019, 3, "R4");
    t_fine_map(16'hE001, 2, "R4");
    t_fine_map(16'h8301, 4, "R4");
    t_fine_map(16'hE319, 1, "R5");
    t_fine_map(16'h9831, 2, "R5");
    t_fine_map(16'h8421, 5, "R5");
    t_fine_map(16'hFFF1, 2, "R4");
    t_limit_zero();
    t_retry();
    t_fail(16'h8001);
    t_fail(16'hFFFF);
    t_hold();
    t_busy_start();
    t_start_with_pulse();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule